// File: doc/BRIEF.md
# Half-Duplex Shared-Shifter Serial Transceiver

This block is an asynchronous serial port that owns one shift register and uses it for both directions. At any moment it is idle, receiving, or sending. A write to the data register always starts a transmission, even when a character is arriving. That character is dropped, because the shifter now holds the outgoing frame. A character that arrives completely is copied to a receive buffer when its stop bit is sampled. The CPU can read the buffer while the line is free for the next character.

The static input `cfg_long_frame` picks the frame size. The short frame has 10 bits. A control bit sets its payload to either eight data bits, or seven data bits plus an even parity bit that the hardware computes. The long frame has 11 bits and adds a ninth data bit. That bit is sent from, and received into, a control bit. In the long frame the sent line is inverted. While nothing is being sent, the TXD pin copies the general-purpose input `port_bit`, so software sets the idle level. A programmable divider makes a sampling tick at eight times the bit rate. For example, a divide value of 13 at 8 MHz gives about 76.8 kbaud.

Register map, where `bus_addr` selects the register:
- 0: data. A write sends the character. A read returns the receive buffer and clears the receive-complete flag and both error flags.
- 1: control/status. Bit 0 selects parity, bit 1 enables the receive interrupt, bit 2 enables the transmit interrupt, and bit 3 is the ninth bit. Bits 4 to 7 are read-only: receive complete, transmit complete, framing error and parity error.
- 2: baud divide value.

Top module: `hdx_uart`

## Requirements
- R1: After reset, irq is 0, TXD equals `port_bit`, register 1 reads 0 and register 2 reads the parameter `DIV_RESET` (13).
- R2: While no frame is being sent, TXD follows `port_bit` at every cycle.
- R3: In the short frame without parity, a data write sends, starting on the next cycle, a 0 start bit, the eight data bits LSB first and a 1 stop bit, each lasting 8 ticks. Transmit complete (register 1 bit 4... bit 5) is then set.
- R4: With register 1 bit 0 set in the short frame, the sent payload is data bits 6..0 followed by a parity bit that makes their count of ones even. Data bit 7 is ignored.
- R5: In the long frame, the sent frame is start, eight data bits LSB first, register 1 bit 3, and stop, and TXD carries the inverse of each bit.
- R6: A received short frame without parity loads all eight data bits into the buffer and sets register 1 bit 4. A read of register 0 returns the buffer and clears that bit.
- R7: With parity selected, a received character puts its seven data bits in the buffer with bit 7 as 0. Bit 7 of register 1 is set exactly when the received parity is not even.
- R8: A received long frame loads its ninth bit into register 1 bit 3 and its eight data bits into the buffer.
- R9: A stop bit sampled low sets register 1 bit 6, and the buffer and receive complete are still updated.
- R10: A falling edge on RXD that is high again at the fourth tick of the start bit is ignored, and no character is received.
- R11: A data write during a reception aborts it. The new frame is sent correctly and receive complete stays 0.
- R12: irq is (register 1 bit 4 AND bit 1) OR (bit 5 AND bit 2). Transmit complete clears on a data write, and receive complete clears on a data read.
- R13: With divide value N, one tick occurs every N clocks, so every bit after the start bit lasts 8·N clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_long_frame | input | 1 | Static frame select: 1 = 11-bit inverted frame, 0 = 10-bit frame |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on register 0) |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| rxd | input | 1 | Serial receive line |
| port_bit | input | 1 | Port level driven on TXD while no frame is sent |
| txd | output | 1 | Serial transmit pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is the takeover of the shared shifter in the middle of a character. The bench drives the start bit and two data bits of an incoming frame by hand and leaves RXD low. It then writes the data register, so the write lands while the receiver is partway through the frame. It then checks every bit of the outgoing frame and confirms that no reception completed. A second hard case is the short start glitch: the bench pulls RXD low for only two clocks, so the start detector fires but the level check at the fourth tick fails.

// File: rtl/hdx_uart_pkg.sv
`timescale 1ns/1ps
package hdx_uart_pkg;

    // Oversampling: eight ticks per bit
    localparam int                 PHASE_W      = 3;
    localparam logic [PHASE_W-1:0] SAMPLE_PHASE = 3'd3;
    localparam logic [PHASE_W-1:0] LAST_PHASE   = 3'd7;

    // Register addresses
    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_DIV  = 2'd2;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RX   = 2'd1,
        ENG_TX   = 2'd2
    } eng_state_e;

endpackage

// File: rtl/hdx_baud_gen.sv
`timescale 1ns/1ps
module hdx_baud_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    // Tick on the last count of each period; a divide value of 0 or 1 ticks every clock
    always_comb begin
        tick  = ({1'b0, cnt_q} + (DIV_W+1)'(1)) >= {1'b0, div};
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/hdx_frame_build.sv
`timescale 1ns/1ps
module hdx_frame_build #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              long_mode,
    input  logic              par_en,
    input  logic              ninth,
    output logic [DATA_W+2:0] frame
);
    // Bit 0 goes out first; unused high positions are padded with idle ones
    always_comb begin
        if (long_mode)
            frame = {1'b1, ninth, data, 1'b0};
        else if (par_en)
            frame = {2'b11, ^data[DATA_W-2:0], data[DATA_W-2:0], 1'b0};
        else
            frame = {2'b11, data, 1'b0};
    end
endmodule

// File: rtl/hdx_engine.sv
`timescale 1ns/1ps
module hdx_engine
    import hdx_uart_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              long_mode,
    input  logic              par_en,
    input  logic              tx_start,
    input  logic [DATA_W+2:0] tx_frame,
    input  logic              rx_in,
    input  logic              rx_fall,
    output logic              tx_active,
    output logic              tx_bit,
    output logic              tx_cmp,
    output logic              rx_cmp,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ninth,
    output logic              rx_ferr,
    output logic              rx_perr
);
    localparam int FW = DATA_W + 3;
    localparam int CW = $clog2(FW);

    typedef struct packed {
        eng_state_e         st;
        logic [PHASE_W-1:0] phase;
        logic [CW-1:0]      idx;
        logic [FW-1:0]      sh;
        logic               tx_cmp;
        logic               rx_cmp;
        logic [DATA_W-1:0]  rdat;
        logic               rnin;
        logic               ferr;
        logic               perr;
    } eng_t;

    eng_t          q, n;
    logic [CW-1:0] last_idx;

    always_comb begin
        last_idx = long_mode ? CW'(FW-1) : CW'(FW-2);
        n        = q;
        n.tx_cmp = 1'b0;
        n.rx_cmp = 1'b0;
        if (tx_start) begin
            // Transmit takes the shifter regardless of the current state
            n.st    = ENG_TX;
            n.phase = '0;
            n.idx   = '0;
            n.sh    = tx_frame;
        end else begin
            case (q.st)
                ENG_IDLE: begin
                    if (rx_fall) begin
                        n.st    = ENG_RX;
                        n.phase = '0;
                        n.idx   = '0;
                    end
                end
                ENG_RX: begin
                    if (tick) begin
                        n.phase = q.phase + 1'b1;
                        if (q.phase == SAMPLE_PHASE) begin
                            if (q.idx == '0) begin
                                if (rx_in) n.st = ENG_IDLE;   // glitch, not a start bit
                            end else if (q.idx == last_idx) begin
                                n.st     = ENG_IDLE;
                                n.rx_cmp = 1'b1;
                                n.ferr   = ~rx_in;
                                if (long_mode) begin
                                    n.rdat = q.sh[FW-2:2];
                                    n.rnin = q.sh[FW-1];
                                    n.perr = 1'b0;
                                end else if (par_en) begin
                                    n.rdat = {1'b0, q.sh[FW-2:3]};
                                    n.rnin = 1'b0;
                                    n.perr = ^q.sh[FW-1:3];
                                end else begin
                                    n.rdat = q.sh[FW-1:3];
                                    n.rnin = 1'b0;
                                    n.perr = 1'b0;
                                end
                            end else begin
                                n.sh = {rx_in, q.sh[FW-1:1]};
                            end
                        end
                        if (q.phase == LAST_PHASE) n.idx = q.idx + 1'b1;
                    end
                end
                ENG_TX: begin
                    if (tick) begin
                        n.phase = q.phase + 1'b1;
                        if (q.phase == LAST_PHASE) begin
                            n.sh = {1'b1, q.sh[FW-1:1]};
                            if (q.idx == last_idx) begin
                                n.st     = ENG_IDLE;
                                n.tx_cmp = 1'b1;
                            end else begin
                                n.idx = q.idx + 1'b1;
                            end
                        end
                    end
                end
                default: n.st = ENG_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign tx_active = (q.st == ENG_TX);
    assign tx_bit    = q.sh[0];
    assign tx_cmp    = q.tx_cmp;
    assign rx_cmp    = q.rx_cmp;
    assign rx_data   = q.rdat;
    assign rx_ninth  = q.rnin;
    assign rx_ferr   = q.ferr;
    assign rx_perr   = q.perr;
endmodule

// File: rtl/hdx_uart.sv
`timescale 1ns/1ps
module hdx_uart
    import hdx_uart_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_long_frame,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rxd,
    input  logic              port_bit,
    output logic              txd,
    output logic              irq
);
    localparam int FW = DATA_W + 3;

    typedef struct packed {
        logic              par_en;
        logic              rx_ie;
        logic              tx_ie;
        logic              ninth;
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] rbuf;
        logic              rx_done;
        logic              tx_done;
        logic              ferr;
        logic              perr;
        logic              s1;
        logic              s2;
        logic              prev;
    } regs_t;

    regs_t             q, n;
    logic              tick;
    logic              wr_data, wr_ctrl, wr_div, rd_data;
    logic              rx_fall;
    logic [FW-1:0]     frame;
    logic              tx_active, tx_bit, eng_tx_cmp, eng_rx_cmp;
    logic [DATA_W-1:0] eng_rdat;
    logic              eng_nin, eng_ferr, eng_perr;
    logic              st_rx_done, st_tx_done;

    hdx_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(q.div), .tick(tick)
    );

    hdx_frame_build #(.DATA_W(DATA_W)) u_frame (
        .data(bus_wdata), .long_mode(cfg_long_frame), .par_en(q.par_en),
        .ninth(q.ninth), .frame(frame)
    );

    hdx_engine #(.DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .long_mode(cfg_long_frame), .par_en(q.par_en),
        .tx_start(wr_data), .tx_frame(frame),
        .rx_in(q.s2), .rx_fall(rx_fall),
        .tx_active(tx_active), .tx_bit(tx_bit), .tx_cmp(eng_tx_cmp),
        .rx_cmp(eng_rx_cmp), .rx_data(eng_rdat), .rx_ninth(eng_nin),
        .rx_ferr(eng_ferr), .rx_perr(eng_perr)
    );

    always_comb begin
        wr_data = bus_wr && (bus_addr == ADDR_DATA);
        wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
        wr_div  = bus_wr && (bus_addr == ADDR_DIV);
        rd_data = bus_rd && (bus_addr == ADDR_DATA);
        rx_fall = q.prev & ~q.s2;

        n      = q;
        n.s1   = rxd;
        n.s2   = q.s1;
        n.prev = q.s2;
        if (wr_ctrl) begin
            n.par_en = bus_wdata[0];
            n.rx_ie  = bus_wdata[1];
            n.tx_ie  = bus_wdata[2];
            n.ninth  = bus_wdata[3];
        end
        if (wr_div)  n.div = bus_wdata[DIV_W-1:0];
        if (rd_data) begin
            n.rx_done = 1'b0;
            n.ferr    = 1'b0;
            n.perr    = 1'b0;
        end
        if (wr_data) n.tx_done = 1'b0;
        // Completion events win over same-cycle clears
        if (eng_rx_cmp) begin
            n.rbuf    = eng_rdat;
            n.rx_done = 1'b1;
            n.ferr    = eng_ferr;
            n.perr    = eng_perr;
            if (cfg_long_frame) n.ninth = eng_nin;
        end
        if (eng_tx_cmp) n.tx_done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.div  <= DIV_W'(DIV_RESET);
            q.s1   <= 1'b1;
            q.s2   <= 1'b1;
            q.prev <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign st_rx_done = q.rx_done;
    assign st_tx_done = q.tx_done;

    always_comb begin
        case (bus_addr)
            ADDR_DATA: bus_rdata = q.rbuf;
            ADDR_CTRL: bus_rdata = DATA_W'({q.perr, q.ferr, q.tx_done, q.rx_done,
                                            q.ninth, q.tx_ie, q.rx_ie, q.par_en});
            ADDR_DIV:  bus_rdata = DATA_W'(q.div);
            default:   bus_rdata = '0;
        endcase
        txd = tx_active ? (cfg_long_frame ? ~tx_bit : tx_bit) : port_bit;
        irq = (st_rx_done & q.rx_ie) | (st_tx_done & q.tx_ie);
    end
endmodule

// File: rtl/hdx_uart_chk.sv
`timescale 1ns/1ps
module hdx_uart_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_long_frame,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [1:0] bus_addr,
    input logic       txd,
    input logic       tx_active,
    input logic       eng_tx_cmp,
    input logic       eng_rx_cmp,
    input logic       st_rx_done
);
    // R11: a data write always takes the shifter on the next cycle
    p_tx_takes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> tx_active);

    // R11: no reception can complete while a frame is being sent
    p_no_rx_in_tx_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |-> !eng_rx_cmp);

    // R3 / R5: first transmitted level is the start bit, inverted in the long frame
    p_start_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_active) |-> (txd == cfg_long_frame));

    // R12: leaving transmit always reports completion
    p_tx_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_active) |-> eng_tx_cmp);

    // R6: a completed reception is flagged on the next cycle
    p_rx_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rx_cmp |=> st_rx_done);

    // R6: a data read clears the flag unless a new character lands at once
    p_rd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd0 && !eng_rx_cmp) |=> !st_rx_done);
endmodule

bind hdx_uart hdx_uart_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_long_frame(cfg_long_frame),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .txd(txd),
    .tx_active(tx_active), .eng_tx_cmp(eng_tx_cmp), .eng_rx_cmp(eng_rx_cmp),
    .st_rx_done(st_rx_done)
);

// File: tb/sim_hdx_uart.sv
`timescale 1ns/1ps
module sim_hdx_uart;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_long_frame = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       rxd = 1'b1, port_bit = 1'b1;
    logic       txd, irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    hdx_uart u0 (
        .clk(clk), .rst_n(rst_n), .cfg_long_frame(cfg_long_frame),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd), .port_bit(port_bit), .txd(txd), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #0.1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_reset(input bit longf);
        @(negedge clk);
        rst_n = 1'b0; cfg_long_frame = longf; rxd = 1'b1; port_bit = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wr(2'd2, 8'd1);
    endtask

    // Called straight after wr to the data register; samples the middle of each bit
    task automatic expect_tx(input string req, input logic [10:0] f, input int nb, input bit inv);
        repeat (4) @(negedge clk);
        for (int k = 0; k < nb; k++) begin
            chk($sformatf("%s bit %0d", req, k), txd, f[k] ^ inv);
            repeat (8) @(negedge clk);
        end
    endtask

    task automatic send_rx(input logic [10:0] f, input int nb);
        for (int k = 0; k < nb; k++) begin
            @(negedge clk);
            rxd = f[k];
            repeat (7) @(negedge clk);
        end
        @(negedge clk);
        rxd = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        @(negedge clk);
        rst_n = 1'b0; port_bit = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq", irq, 0);
        chk("R1 txd", txd, 1);
        rd(2'd1, v); chk("R1 ctrl", v, 8'h00);
        rd(2'd2, v); chk("R1 divider", v, 8'd13);
        port_bit = 1'b0; @(negedge clk);
        chk("R2 idle txd low", txd, 0);
        port_bit = 1'b1; @(negedge clk);
        chk("R2 idle txd high", txd, 1);
        wr(2'd2, 8'd1);
    endtask

    task automatic t_tx8();
        logic [7:0] v;
        wr(2'd1, 8'h00);
        wr(2'd0, 8'hA5);
        expect_tx("R3", {2'b11, 8'hA5, 1'b0}, 10, 1'b0);
        rd(2'd1, v); chk("R3 tx done", v[5], 1);
        port_bit = 1'b0; @(negedge clk);
        chk("R2 txd after frame", txd, 0);
        port_bit = 1'b1;
    endtask

    task automatic t_tx_par();
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h07);
        expect_tx("R4 parity one", {2'b11, 1'b1, 7'h07, 1'b0}, 10, 1'b0);
        wr(2'd0, 8'h83);
        expect_tx("R4 top bit ignored", {2'b11, 1'b0, 7'h03, 1'b0}, 10, 1'b0);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_tx11();
        do_reset(1'b1);
        wr(2'd1, 8'h08);
        wr(2'd0, 8'h3C);
        expect_tx("R5 ninth set", {1'b1, 1'b1, 8'h3C, 1'b0}, 11, 1'b1);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h81);
        expect_tx("R5 ninth clear", {1'b1, 1'b0, 8'h81, 1'b0}, 11, 1'b1);
    endtask

    task automatic t_rx11();
        logic [7:0] v;
        wr(2'd1, 8'h00);
        send_rx({1'b1, 1'b1, 8'hC3, 1'b0}, 11);
        rd(2'd1, v); chk("R8 ninth received", v[3], 1);
        chk("R8 rx done", v[4], 1);
        rd(2'd0, v); chk("R8 data", v, 8'hC3);
        send_rx({1'b1, 1'b0, 8'h5E, 1'b0}, 11);
        rd(2'd1, v); chk("R8 ninth zero", v[3], 0);
        rd(2'd0, v); chk("R8 data 2", v, 8'h5E);
    endtask

    task automatic t_rx8();
        logic [7:0] v;
        do_reset(1'b0);
        send_rx({2'b11, 8'h5A, 1'b0}, 10);
        rd(2'd1, v); chk("R6 rx done", v[4], 1);
        rd(2'd0, v); chk("R6 data", v, 8'h5A);
        rd(2'd1, v); chk("R6 flag cleared", v[4], 0);
    endtask

    task automatic t_rx_par();
        logic [7:0] v;
        wr(2'd1, 8'h01);
        send_rx({2'b11, 1'b1, 7'h15, 1'b0}, 10);
        rd(2'd1, v); chk("R7 good parity", v[7], 0);
        rd(2'd0, v); chk("R7 data", v, 8'h15);
        send_rx({2'b11, 1'b0, 7'h15, 1'b0}, 10);
        rd(2'd1, v); chk("R7 bad parity", v[7], 1);
        rd(2'd0, v); chk("R7 data bit7 zero", v, 8'h15);
        rd(2'd1, v); chk("R7 error cleared", v[7], 0);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_ferr();
        logic [7:0] v;
        send_rx({2'b10, 8'h11, 1'b0}, 10);
        rd(2'd1, v); chk("R9 framing error", v[6], 1);
        chk("R9 rx done", v[4], 1);
        rd(2'd0, v); chk("R9 buffer updated", v, 8'h11);
        rd(2'd1, v); chk("R9 error cleared", v[6], 0);
    endtask

    task automatic t_glitch();
        logic [7:0] v;
        @(negedge clk); rxd = 1'b0;
        repeat (2) @(negedge clk); rxd = 1'b1;
        repeat (100) @(negedge clk);
        rd(2'd1, v); chk("R10 glitch ignored", v[4], 0);
        rd(2'd0, v); chk("R10 buffer unchanged", v, 8'h11);
    endtask

    task automatic t_preempt();
        logic [7:0] v;
        @(negedge clk); rxd = 1'b0;
        repeat (8) @(negedge clk); rxd = 1'b1;
        repeat (8) @(negedge clk); rxd = 1'b0;
        repeat (5) @(negedge clk);
        wr(2'd0, 8'h55);
        rxd = 1'b1;
        expect_tx("R11 frame", {2'b11, 8'h55, 1'b0}, 10, 1'b0);
        rd(2'd1, v); chk("R11 no rx done", v[4], 0);
        chk("R11 tx done", v[5], 1);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        wr(2'd1, 8'h06);
        @(negedge clk); chk("R12 irq from old tx done", irq, 1);
        wr(2'd1, 8'h02);
        @(negedge clk); chk("R12 masked", irq, 0);
        wr(2'd1, 8'h06);
        wr(2'd0, 8'h00);
        chk("R12 data write clears", irq, 0);
        repeat (84) @(negedge clk);
        chk("R12 tx irq", irq, 1);
        wr(2'd1, 8'h02);
        send_rx({2'b11, 8'h3E, 1'b0}, 10);
        chk("R12 rx irq", irq, 1);
        rd(2'd0, v);
        chk("R12 data read clears", irq, 0);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_baud();
        int cnt;
        int guard;
        wr(2'd2, 8'd3);
        wr(2'd0, 8'h01);
        guard = 0;
        while (txd !== 1'b1 && guard < 200) begin @(negedge clk); guard++; end
        cnt = 0;
        while (txd === 1'b1 && cnt < 200) begin cnt++; @(negedge clk); end
        chk("R13 bit length", cnt, 24);
        repeat (260) @(negedge clk);
        wr(2'd2, 8'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_tx8();
        t_tx_par();
        t_rx8();
        t_rx_par();
        t_ferr();
        t_glitch();
        t_preempt();
        t_irq();
        t_baud();
        t_tx11();
        t_rx11();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule